// File: doc/BRIEF.md
# Dual-Filtered 192-bit LFSR Generator

This block holds a 192-stage maximum-length Fibonacci shift register and reads its state through two identical 7-input symmetric filters. Each filter returns the XOR of every pairwise AND of its inputs, which is bit 1 of the inputs' population count. Every enabled step therefore produces two pseudorandom bits, one from each filter, and a downstream stage can take them in the order first-filter bit, then second-filter bit.

The starting state is written through a parallel load port; any nonzero 192-bit value is accepted. Producing that starting value from key material is the job of surrounding logic. A load takes priority over a step. Both filter bits of a step are taken from the state as it stands before that step's shift, and they appear on a registered output one clock after the edge that performs the step. The asynchronous active-low reset is released on the clock through a two-flop synchronizer. After reset the state register holds the nonzero value given by a parameter.

Top module: `dfl_gen`

## Requirements
- R1: While reset is active, and until the first step after reset, `bits_valid_o` is 0 and `bits_o` is 2'b00.
- R2: When `load_i` is 1 at a clock edge, the state becomes `load_state_i` and `bits_valid_o` is 0 in the following cycle, whatever the value of `step_i`.
- R3: At an edge where `step_i` is 1 and `load_i` is 0, every state bit i moves to index i-1 and index 191 receives the XOR of state bits 0, 3, 4, 23, 36, 37, 60, 61, 98, 115, 146, 175, 176 and 187.
- R4: `bits_o[0]` after a step is bit 1 of the population count of the pre-step state bits 1, 32, 40, 101, 164, 178 and 187.
- R5: `bits_o[1]` after a step is bit 1 of the population count of the pre-step state bits 6, 8, 60, 116, 145, 181 and 191.
- R6: Both output bits of one step are computed from the same state, taken before that step's shift. They appear together in the cycle after the stepping edge, with `bits_valid_o` set to 1.
- R7: At an edge where both `step_i` and `load_i` are 0, the state does not change and `bits_valid_o` is 0 in the next cycle. The next step continues the sequence with no gap.
- R8: `bits_o` keeps its last value in every cycle that follows an edge with no step taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Load strobe; copies load_state_i into the state |
| load_state_i | input | 192 | Parallel state value to load |
| step_i | input | 1 | Step enable |
| bits_o | output | 2 | [0] first-filter bit, [1] second-filter bit |
| bits_valid_o | output | 1 | bits_o holds the result of the previous edge's step |

## Verification
The assertions check on every cycle the control behaviour of the block. They cover load priority over a step, the valid flag following an accepted step, the state holding and the output bits holding in idle cycles, a loaded state arriving intact, and the one-place downward move of the state bits on a step. They cannot show that the feedback bit and the two filter bits take the right values. The bench shows this by comparing every cycle against a bit-serial model of the recursion and of the filters. It runs several thousand steps from several random seeds with random idles and loads. It also uses directed states whose set bits lie only on one filter's taps, so the two outputs are told apart and their order is confirmed.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  localparam int unsigned STATE_W  = 192;
  localparam int unsigned FB_NTAPS = 14;
  localparam int unsigned FLT_N    = 7;
  localparam int unsigned OUT_W    = 2;

  // positions XORed into the feedback bit (relative to the oldest bit)
  localparam int unsigned FB_TAPS [FB_NTAPS] =
    '{0, 3, 4, 23, 36, 37, 60, 61, 98, 115, 146, 175, 176, 187};

  // filter tap sets
  localparam int unsigned FLT_A_TAPS [FLT_N] = '{1, 32, 40, 101, 164, 178, 187};
  localparam int unsigned FLT_B_TAPS [FLT_N] = '{6, 8, 60, 116, 145, 181, 191};

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [OUT_W-1:0]   obits_t;
endpackage

// File: rtl/dfl_rst_sync.sv
module dfl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/dfl_sym_filter.sv
module dfl_sym_filter #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] taps_i,
  output logic         bit_o
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [CW-1:0] pop;

  // sum of pairwise products mod 2 equals bit 1 of the weight
  always_comb begin
    pop = '0;
    for (int i = 0; i < N; i++) begin
      pop = pop + CW'(taps_i[i]);
    end
  end

  assign bit_o = pop[1];
endmodule

// File: rtl/dfl_lfsr_core.sv
module dfl_lfsr_core
  import dfl_pkg::*;
#(
  parameter state_t RST_STATE = state_t'(1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  state_t load_state_i,
  input  logic   step_i,
  output state_t state_o
);
  state_t               state_q;
  state_t               state_d;
  logic [FB_NTAPS-1:0]  fb_terms;
  logic                 fb_bit;

  for (genvar g = 0; g < FB_NTAPS; g++) begin : g_fb
    assign fb_terms[g] = state_q[FB_TAPS[g]];
  end

  assign fb_bit = ^fb_terms;

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = load_state_i;
    end else if (step_i) begin
      state_d = {fb_bit, state_q[STATE_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RST_STATE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dfl_out_stage.sv
module dfl_out_stage
  import dfl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fire_i,
  input  obits_t bits_i,
  output obits_t bits_o,
  output logic   valid_o
);
  obits_t bits_q, bits_d;
  logic   valid_q, valid_d;

  always_comb begin
    bits_d  = bits_q;
    valid_d = fire_i;
    if (fire_i) bits_d = bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      bits_q  <= bits_d;
      valid_q <= valid_d;
    end
  end

  assign bits_o  = bits_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dfl_gen.sv
module dfl_gen
  import dfl_pkg::*;
#(
  parameter state_t RST_STATE = state_t'(1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STATE_W-1:0] load_state_i,
  input  logic               step_i,
  output logic [OUT_W-1:0]   bits_o,
  output logic               bits_valid_o
);
  logic             rst_sync_n;
  state_t           state_q;
  logic [FLT_N-1:0] flt_a_in;
  logic [FLT_N-1:0] flt_b_in;
  obits_t           flt_bits;
  logic             step_fire;

  dfl_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  dfl_lfsr_core #(.RST_STATE(RST_STATE)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .load_i       (load_i),
    .load_state_i (load_state_i),
    .step_i       (step_i),
    .state_o      (state_q)
  );

  for (genvar k = 0; k < FLT_N; k++) begin : g_taps
    assign flt_a_in[k] = state_q[FLT_A_TAPS[k]];
    assign flt_b_in[k] = state_q[FLT_B_TAPS[k]];
  end

  dfl_sym_filter #(.N(FLT_N)) u_flt_a (
    .taps_i (flt_a_in),
    .bit_o  (flt_bits[0])
  );

  dfl_sym_filter #(.N(FLT_N)) u_flt_b (
    .taps_i (flt_b_in),
    .bit_o  (flt_bits[1])
  );

  assign step_fire = step_i & ~load_i;

  dfl_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .fire_i  (step_fire),
    .bits_i  (flt_bits),
    .bits_o  (bits_o),
    .valid_o (bits_valid_o)
  );
endmodule

// File: rtl/dfl_gen_chk.sv
module dfl_gen_chk
  import dfl_pkg::*;
(
  input logic   clk_i,
  input logic   rst_n_i,
  input logic   load_i,
  input state_t load_state_i,
  input logic   step_i,
  input state_t state_i,
  input obits_t bits_o,
  input logic   bits_valid_o
);
  // R2: a loaded value arrives intact
  p_load_state_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_i |=> (state_i == $past(load_state_i)));

  // R2: load wins over step
  p_load_priority_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_i |=> !bits_valid_o);

  // R3: state moves down one place on a step
  p_shift_down_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (step_i && !load_i) |=> (state_i[STATE_W-2:0] == $past(state_i[STATE_W-1:1])));

  // R6: accepted step gives valid one cycle later
  p_valid_after_step_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (step_i && !load_i) |=> bits_valid_o);

  // R7: idle holds the state and gives no valid
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!step_i && !load_i) |=> ($stable(state_i) && !bits_valid_o));

  // R8: output bits hold when no step is taken
  p_bits_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(step_i && !load_i) |=> $stable(bits_o));

  // R1: outputs quiet in reset
  always_comb begin
    if (!rst_n_i) begin
      p_reset_quiet_r1: assert (bits_valid_o == 1'b0 && bits_o == '0);
    end
  end
endmodule

bind dfl_gen dfl_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_sync_n),
  .load_i       (load_i),
  .load_state_i (load_state_i),
  .step_i       (step_i),
  .state_i      (state_q),
  .bits_o       (bits_o),
  .bits_valid_o (bits_valid_o)
);

// File: tb/tb_dfl_gen.sv
module tb_dfl_gen;
  logic         clk;
  logic         rst_n;
  logic         load;
  logic [191:0] load_val;
  logic         step;
  logic [1:0]   bits;
  logic         valid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [191:0] m_state;
  logic [1:0]   m_bits;

  int fb_pos [14] = '{0, 3, 4, 23, 36, 37, 60, 61, 98, 115, 146, 175, 176, 187};
  int fa_pos [7]  = '{1, 32, 40, 101, 164, 178, 187};
  int fbb_pos [7] = '{6, 8, 60, 116, 145, 181, 191};

  dfl_gen dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .load_i       (load),
    .load_state_i (load_val),
    .step_i       (step),
    .bits_o       (bits),
    .bits_valid_o (valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic pair_xor(logic [191:0] s, int which);
    logic acc = 1'b0;
    for (int j = 0; j < 7; j++) begin
      for (int k = j + 1; k < 7; k++) begin
        if (which == 0) acc ^= s[fa_pos[j]] & s[fa_pos[k]];
        else            acc ^= s[fbb_pos[j]] & s[fbb_pos[k]];
      end
    end
    return acc;
  endfunction

  function automatic logic [191:0] advance(logic [191:0] s);
    logic fb = 1'b0;
    for (int i = 0; i < 14; i++) fb ^= s[fb_pos[i]];
    return {fb, s[191:1]};
  endfunction

  function automatic logic [191:0] rand_state();
    logic [191:0] v;
    for (int i = 0; i < 6; i++) v[i*32 +: 32] = $urandom;
    if (v == '0) v[0] = 1'b1;
    return v;
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: {valid,bits} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drives at a falling edge, checks at the next falling edge
  task automatic cycle(logic ld, logic [191:0] v, logic st, string tag);
    logic ev;
    load = ld; load_val = v; step = st;
    @(posedge clk);
    @(negedge clk);
    if (ld) begin
      m_state = v; ev = 1'b0;
    end else if (st) begin
      m_bits = {pair_xor(m_state, 1), pair_xor(m_state, 0)};
      m_state = advance(m_state); ev = 1'b1;
    end else begin
      ev = 1'b0;
    end
    check(tag, {valid, bits}, {ev, m_bits});
  endtask

  function automatic logic [191:0] only_taps(int which);
    logic [191:0] v = '0;
    for (int i = 0; i < 7; i++) begin
      if (which == 0) v[fa_pos[i]] = 1'b1;
      else            v[fbb_pos[i]] = 1'b1;
    end
    return v;
  endfunction

  initial begin
    logic [191:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; load = 1'b0; step = 1'b0; load_val = '0;
    m_state = 192'd1; m_bits = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 in reset", {valid, bits}, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {valid, bits}, 3'b000);

    // steps from the reset state
    for (int i = 0; i < 20; i++) cycle(1'b0, '0, 1'b1, "R3 reset seed");

    // directed: all ones, both filters weight 7
    cycle(1'b1, '1, 1'b0, "R2 load ones");
    cycle(1'b0, '0, 1'b1, "R4 R5 all ones");
    // only first filter taps set
    cycle(1'b1, only_taps(0), 1'b1, "R2 load with step");
    cycle(1'b0, '0, 1'b1, "R4 first tap set");
    cycle(1'b0, '0, 1'b0, "R7 R8 idle");
    cycle(1'b0, '0, 1'b1, "R6 after shift");
    // only second filter taps set
    cycle(1'b1, only_taps(1), 1'b0, "R2 load");
    cycle(1'b0, '0, 1'b1, "R5 second tap set");
    for (int i = 0; i < 8; i++) cycle(1'b0, '0, 1'b1, "R6 shifted taps");
    // three taps of the first set: weight 3 gives 1
    v = '0; v[1] = 1'b1; v[101] = 1'b1; v[187] = 1'b1; v[6] = 1'b1;
    cycle(1'b1, v, 1'b0, "R2 load");
    cycle(1'b0, '0, 1'b1, "R4 R5 weight mix");

    // random phase from several seeds
    for (int s = 0; s < 5; s++) begin
      cycle(1'b1, rand_state(), 1'b0, "R2 seed load");
      for (int n = 0; n < 1200; n++) begin
        int r;
        r = $urandom % 100;
        if (r < 2)       cycle(1'b1, rand_state(), r == 0, "R2 random load");
        else if (r < 85) cycle(1'b0, '0, 1'b1, "R3 R4 R5 R6 random step");
        else             cycle(1'b0, '0, 1'b0, "R7 R8 random idle");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule